// File: doc/BRIEF.md
# Floating Result Sign and Rounding Unit

This unit is the last step of a floating-point datapath. It receives an unpacked result as a sign, a two's-complement unbiased exponent and a 64-bit mantissa. The mantissa has 10 integer bits and 54 fraction bits, so a normalized value has its leading one at bit 54. The unit also receives the rounding mode, a single/double precision select, a negate request, a flag marking an exactly zero subtraction result, and a NaN flag.

In the first cycle it decides the final sign and registers it together with the operands. In the second cycle that registered sign drives both the rounding direction and the packed word. The mantissa is rounded to the selected precision by adding a single one at the precision's last kept bit. The bits below that position are then cleared on the adder output. The unit flags inexact results and emits the packed 64-bit word along with the sign the result-class logic needs.

Single-precision results are delivered in the 64-bit storage format with the low fraction bits zero. Exponent range checks are left to the surrounding datapath.

Top module: `fpfin_result_unit`

## Requirements
- R1: A result appears on the outputs with `valid_o` high exactly two clock cycles after `valid_i` is sampled high; `valid_o` is low in every other cycle.
- R2: With `rmode_i` = 00 (nearest, ties to even), the kept mantissa is incremented when the discarded part exceeds half a unit in the last place, or equals exactly half and the last kept bit is 1.
- R3: With `rmode_i` = 01 (toward zero), discarded bits are dropped and the kept bits are never incremented.
- R4: With `rmode_i` = 10 (toward +inf) the kept mantissa is incremented when any discarded bit is set and the final sign is 0; with `rmode_i` = 11 (toward -inf) when any discarded bit is set and the final sign is 1.
- R5: With `single_i` = 0 the last kept mantissa bit is bit 2; with `single_i` = 1 it is bit 31, and packed result bits 28..0 are zero.
- R6: If rounding carries the mantissa up to bit 55, the mantissa is shifted right by one and the exponent is incremented by one.
- R7: `inexact_o` is 1 exactly when a non-NaN result has a nonzero bit below the last kept position.
- R8: When `sub_zero_i` is 1 and `nan_i` is 0, the sign before negation is 1 if `rmode_i` = 11 and 0 in every other mode, whatever `sign_i` is.
- R9: `negate_i` inverts the sign after the R8 rule has been applied.
- R10: When `nan_i` is 1, the result sign equals `sign_i` whatever `negate_i` and `sub_zero_i` are. The exponent field is all ones, the fraction is mantissa bits 53..2 unrounded, and `inexact_o` is 0.
- R11: `class_sign_o` equals bit 63 of `result_o` whenever `valid_o` is high.
- R12: The packed word has the sign at bit 63, the biased exponent (exponent + 1023, low 11 bits) at bits 62..52, and rounded mantissa bits 53..2 at bits 51..0. A zero mantissa packs as all zeros below the sign.
- R13: While `rst_ni` is low, `valid_o`, `result_o`, `inexact_o` and `class_sign_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input operands valid |
| sign_i | input | 1 | Sign of the unrounded result |
| exp_i | input | 13 | Unbiased exponent, two's complement |
| mant_i | input | 64 | Mantissa, 10 integer and 54 fraction bits |
| rmode_i | input | 2 | Rounding mode: 00 nearest-even, 01 zero, 10 +inf, 11 -inf |
| single_i | input | 1 | 1 rounds to single precision, 0 to double |
| negate_i | input | 1 | Invert the final sign (negated multiply-add forms) |
| sub_zero_i | input | 1 | Result is an exact zero from a subtraction |
| nan_i | input | 1 | Result is a NaN |
| valid_o | output | 1 | Output result valid |
| result_o | output | 64 | Packed result |
| inexact_o | output | 1 | Discarded bits were nonzero |
| class_sign_o | output | 1 | Sign for the result-class flags |

## Verification
The case hardest to reach is one in which the negate request, the zero-subtraction rule and the directed rounding all depend on the same registered sign. In that case a wrong ordering of the sign steps changes both the packed sign and the rounding direction together. The stimulus pairs negated inputs with directed modes and inexact mantissas, so that a sign applied before or after the wrong step shows up as a one-ulp error as well as a flipped sign bit. The carry corner is driven with an all-ones mantissa at both precisions, and ties are placed exactly at the guard bit of each precision.

// File: rtl/fpfin_pkg.sv
package fpfin_pkg;
  parameter int MANT_W  = 64;
  parameter int INT_W   = 10;
  parameter int EXP_W   = 13;
  parameter int DP_FRAC = 52;
  parameter int SP_FRAC = 23;
  parameter int EFLD_W  = 11;

  localparam int FRAC_W = MANT_W - INT_W;
  localparam int DP_LSB = FRAC_W - DP_FRAC;
  localparam int SP_LSB = FRAC_W - SP_FRAC;
  localparam int EBIAS  = (1 << (EFLD_W - 1)) - 1;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;
endpackage

// File: rtl/fpfin_sign_sel.sv
module fpfin_sign_sel
  import fpfin_pkg::*;
(
  input  logic   sign_i,
  input  logic   sub_zero_i,
  input  logic   negate_i,
  input  logic   nan_i,
  input  rmode_e rmode_i,
  output logic   sign_o
);
  logic zero_sign;

  // zero rule first, negation second, NaN sign untouched
  always_comb begin
    zero_sign = sub_zero_i ? (rmode_i == RM_DOWN) : sign_i;
    sign_o    = nan_i ? sign_i : (zero_sign ^ negate_i);
  end
endmodule

// File: rtl/fpfin_round.sv
module fpfin_round
  import fpfin_pkg::*;
(
  input  logic [MANT_W-1:0] mant_i,
  input  logic              single_i,
  input  logic              sign_i,
  input  rmode_e            rmode_i,
  output logic [MANT_W-1:0] mant_o,
  output logic              carry_o,
  output logic              inexact_o
);
  localparam logic [MANT_W-1:0] DP_ONE = MANT_W'(1) << DP_LSB;
  localparam logic [MANT_W-1:0] SP_ONE = MANT_W'(1) << SP_LSB;

  logic [MANT_W-1:0] one_at, low_mask, sum, trimmed;
  logic              guard, sticky, kept_lsb, incr;

  always_comb begin
    one_at    = single_i ? SP_ONE : DP_ONE;
    low_mask  = one_at - MANT_W'(1);
    guard     = |(mant_i & (one_at >> 1));
    sticky    = |(mant_i & (low_mask >> 1));
    kept_lsb  = |(mant_i & one_at);
    inexact_o = |(mant_i & low_mask);
    unique case (rmode_i)
      RM_NEAR: incr = guard & (sticky | kept_lsb);
      RM_ZERO: incr = 1'b0;
      RM_UP:   incr = inexact_o & ~sign_i;
      default: incr = inexact_o & sign_i;
    endcase
    sum     = mant_i + (incr ? one_at : '0);
    // trim after the adder
    trimmed = sum & ~low_mask;
    carry_o = trimmed[FRAC_W+1];
    mant_o  = carry_o ? (trimmed >> 1) : trimmed;
  end
endmodule

// File: rtl/fpfin_pack.sv
module fpfin_pack
  import fpfin_pkg::*;
(
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              carry_i,
  input  logic [MANT_W-1:0] rnd_mant_i,
  input  logic [MANT_W-1:0] raw_mant_i,
  input  logic              nan_i,
  output logic [63:0]       word_o
);
  logic [EXP_W-1:0] exp_b;

  always_comb begin
    exp_b = exp_i + EXP_W'(EBIAS) + EXP_W'(carry_i);
    if (nan_i)
      word_o = {sign_i, {EFLD_W{1'b1}}, raw_mant_i[FRAC_W-1:DP_LSB]};
    else if (rnd_mant_i == '0)
      word_o = {sign_i, 63'd0};
    else
      word_o = {sign_i, exp_b[EFLD_W-1:0], rnd_mant_i[FRAC_W-1:DP_LSB]};
  end
endmodule

// File: rtl/fpfin_result_unit.sv
module fpfin_result_unit
  import fpfin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [1:0]        rmode_i,
  input  logic              single_i,
  input  logic              negate_i,
  input  logic              sub_zero_i,
  input  logic              nan_i,
  output logic              valid_o,
  output logic [63:0]       result_o,
  output logic              inexact_o,
  output logic              class_sign_o
);
  logic              sign_d;
  logic              s1_valid, s1_sign, s1_single, s1_nan;
  logic [EXP_W-1:0]  s1_exp;
  logic [MANT_W-1:0] s1_mant;
  rmode_e            s1_rmode;
  logic [MANT_W-1:0] rnd_mant;
  logic              rnd_carry, rnd_inexact;
  logic [63:0]       packed_word;

  fpfin_sign_sel u_sign (
    .sign_i     (sign_i),
    .sub_zero_i (sub_zero_i),
    .negate_i   (negate_i),
    .nan_i      (nan_i),
    .rmode_i    (rmode_e'(rmode_i)),
    .sign_o     (sign_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid  <= 1'b0;
      s1_sign   <= 1'b0;
      s1_single <= 1'b0;
      s1_nan    <= 1'b0;
      s1_exp    <= '0;
      s1_mant   <= '0;
      s1_rmode  <= RM_NEAR;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_sign   <= sign_d;
        s1_single <= single_i;
        s1_nan    <= nan_i;
        s1_exp    <= exp_i;
        s1_mant   <= mant_i;
        s1_rmode  <= rmode_e'(rmode_i);
      end
    end
  end

  fpfin_round u_round (
    .mant_i    (s1_mant),
    .single_i  (s1_single),
    .sign_i    (s1_sign),
    .rmode_i   (s1_rmode),
    .mant_o    (rnd_mant),
    .carry_o   (rnd_carry),
    .inexact_o (rnd_inexact)
  );

  fpfin_pack u_pack (
    .sign_i     (s1_sign),
    .exp_i      (s1_exp),
    .carry_i    (rnd_carry),
    .rnd_mant_i (rnd_mant),
    .raw_mant_i (s1_mant),
    .nan_i      (s1_nan),
    .word_o     (packed_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      result_o     <= '0;
      inexact_o    <= 1'b0;
      class_sign_o <= 1'b0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) begin
        result_o     <= packed_word;
        inexact_o    <= rnd_inexact & ~s1_nan;
        class_sign_o <= s1_sign;
      end
    end
  end

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |=> valid_o);
  assert_no_spurious_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid |=> !valid_o);
  assert_sp_trim_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_single && !s1_nan) |-> (rnd_mant[SP_LSB-1:0] == '0));
  assert_renorm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && !s1_nan && s1_mant[FRAC_W]) |->
      (rnd_mant[FRAC_W] && rnd_mant[MANT_W-1:FRAC_W+1] == '0));
  assert_exact_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_mant == '0) |=> !inexact_o);
  assert_zero_sign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sub_zero_i && !nan_i && !negate_i) |=> (s1_sign == ($past(rmode_i) == 2'b11)));
  assert_neg_after_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sub_zero_i && !nan_i && negate_i) |=> (s1_sign == ($past(rmode_i) != 2'b11)));
  assert_nan_sign_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && nan_i) |=> (s1_sign == $past(sign_i)));
  assert_class_match_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (class_sign_o == result_o[63]));
endmodule

// File: tb/fpfin_result_unit_tb_top.sv
module fpfin_result_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, sign_i = 1'b0, single_i = 1'b0;
  logic        negate_i = 1'b0, sub_zero_i = 1'b0, nan_i = 1'b0;
  logic [12:0] exp_i = '0;
  logic [63:0] mant_i = '0;
  logic [1:0]  rmode_i = '0;
  logic        valid_o, inexact_o, class_sign_o;
  logic [63:0] result_o;

  int checks = 0, fails = 0, sent = 0, seen = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] word;
    logic        inx;
    logic        csign;
    string       tag;
  } exp_t;
  exp_t sb[$];

  localparam logic [63:0] ONE = 64'h0040_0000_0000_0000;

  always #4 clk_i = ~clk_i;

  fpfin_result_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sign_i(sign_i),
    .exp_i(exp_i), .mant_i(mant_i), .rmode_i(rmode_i), .single_i(single_i),
    .negate_i(negate_i), .sub_zero_i(sub_zero_i), .nan_i(nan_i),
    .valid_o(valid_o), .result_o(result_o), .inexact_o(inexact_o),
    .class_sign_o(class_sign_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic exp_t model(logic s, logic [12:0] e, logic [63:0] m, logic [1:0] rm,
                                 logic sp, logic ng, logic sz, logic nn, string tag);
    exp_t r;
    logic fs, bump;
    int lsb;
    logic [63:0] kept, rem, half, full;
    logic [12:0] eb;
    fs = nn ? s : ((sz ? (rm == 2'b11) : s) ^ ng);
    lsb = sp ? 31 : 2;
    kept = m >> lsb;
    rem = m - (kept << lsb);
    half = 64'd1 << (lsb - 1);
    case (rm)
      2'b00: bump = (rem > half) || (rem == half && kept[0]);
      2'b01: bump = 1'b0;
      2'b10: bump = (rem != 0) && !fs;
      default: bump = (rem != 0) && fs;
    endcase
    full = (kept + 64'(bump)) << lsb;
    eb = e + 13'd1023;
    if (full[55]) begin full = full >> 1; eb = eb + 13'd1; end
    r.tag = tag;
    r.csign = fs;
    if (nn) begin
      r.word = {fs, 11'h7FF, m[53:2]};
      r.inx = 1'b0;
    end else if (m == 0) begin
      r.word = {fs, 63'd0};
      r.inx = 1'b0;
    end else begin
      r.word = {fs, eb[10:0], full[53:2]};
      r.inx = (rem != 0);
    end
    return r;
  endfunction

  task automatic send(logic s, logic [12:0] e, logic [63:0] m, logic [1:0] rm,
                      logic sp, logic ng, logic sz, logic nn, string tag);
    @(negedge clk_i);
    valid_i = 1'b1; sign_i = s; exp_i = e; mant_i = m; rmode_i = rm;
    single_i = sp; negate_i = ng; sub_zero_i = sz; nan_i = nn;
    sb.push_back(model(s, e, m, rm, sp, ng, sz, nn, tag));
    sent++;
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && valid_o) begin
        exp_t x;
        seen++;
        if (sb.size() == 0) begin
          check("R1 unexpected output", 64'(valid_o), 64'd0);
        end else begin
          x = sb.pop_front();
          check({x.tag, " word R12"}, result_o, x.word);
          check({x.tag, " inexact R7"}, 64'(inexact_o), 64'(x.inx));
          check({x.tag, " class sign R11"}, 64'(class_sign_o), 64'(x.csign));
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R13 reset valid_o", 64'(valid_o), 64'd0);
    check("R13 reset result_o", result_o, 64'd0);
    check("R13 reset flags", 64'({inexact_o, class_sign_o}), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1 latency: nothing one cycle after the input
    send(0, 13'd0, ONE | 64'd3, 2'b00, 0, 0, 0, 0, "R1");
    idle();
    check("R1 latency early", 64'(valid_o), 64'd0);
    @(negedge clk_i);
    check("R1 latency on time", 64'(valid_o), 64'd1);
    idle();

    // R2 nearest-even: tie with even lsb, tie with odd lsb, above half
    send(0, 13'd5, ONE | 64'd2, 2'b00, 0, 0, 0, 0, "R2 tie even");
    send(0, 13'd5, ONE | 64'd6, 2'b00, 0, 0, 0, 0, "R2 tie odd");
    send(1, -13'sd7, ONE | 64'd3, 2'b00, 0, 0, 0, 0, "R2 above half");
    // R3 toward zero
    send(0, 13'd1, ONE | 64'd3, 2'b01, 0, 0, 0, 0, "R3 trunc");
    send(1, 13'd1, ONE | 64'hFFFF_FFFF, 2'b01, 1, 0, 0, 0, "R3 trunc sp");
    // R4 directed
    send(0, 13'd2, ONE | 64'd1, 2'b10, 0, 0, 0, 0, "R4 up pos");
    send(1, 13'd2, ONE | 64'd1, 2'b10, 0, 0, 0, 0, "R4 up neg");
    send(1, 13'd2, ONE | 64'd1, 2'b11, 0, 0, 0, 0, "R4 down neg");
    send(0, 13'd2, ONE | 64'd1, 2'b11, 0, 0, 0, 0, "R4 down pos");
    // R4 with R9: negation drives rounding direction
    send(0, 13'd3, ONE | 64'd1, 2'b10, 0, 1, 0, 0, "R4 R9 negated up");
    send(0, 13'd3, ONE | 64'd1, 2'b11, 0, 1, 0, 0, "R4 R9 negated down");
    // R5 single precision: ties at bit 30
    send(0, 13'd0, ONE | (64'd1 << 30), 2'b00, 1, 0, 0, 0, "R5 sp tie even");
    send(0, 13'd0, ONE | (64'd3 << 30), 2'b00, 1, 0, 0, 0, "R5 sp tie odd");
    send(0, 13'd0, ONE | 64'd4, 2'b00, 1, 0, 0, 0, "R5 sp small");
    // R6 carry
    send(0, 13'd10, 64'h007F_FFFF_FFFF_FFFF, 2'b00, 0, 0, 0, 0, "R6 carry dp");
    send(1, 13'd10, 64'h007F_FFFF_FFFF_FFFF, 2'b11, 1, 0, 0, 0, "R6 carry sp");
    // R7 exact
    send(0, 13'd4, ONE | 64'd4, 2'b10, 0, 0, 0, 0, "R7 exact dp");
    send(0, 13'd4, ONE | (64'd1 << 31), 2'b10, 1, 0, 0, 0, "R7 exact sp");
    // R8 / R9 zero subtraction sign
    send(1, 13'd0, 64'd0, 2'b00, 0, 0, 1, 0, "R8 zero near");
    send(1, 13'd0, 64'd0, 2'b10, 0, 0, 1, 0, "R8 zero up");
    send(0, 13'd0, 64'd0, 2'b11, 0, 0, 1, 0, "R8 zero down");
    send(0, 13'd0, 64'd0, 2'b00, 0, 1, 1, 0, "R9 zero near neg");
    send(0, 13'd0, 64'd0, 2'b11, 0, 1, 1, 0, "R9 zero down neg");
    // R10 NaN
    send(1, 13'd0, ONE | 64'h0020_0000_0000_0003, 2'b10, 0, 1, 1, 1, "R10 nan neg");
    send(0, 13'd0, ONE | 64'h0000_0000_8000_0001, 2'b11, 1, 1, 0, 1, "R10 nan sp");
    idle();
    repeat (3) @(negedge clk_i);

    // mixed patterns
    for (int i = 0; i < 60; i++) begin
      logic [63:0] m;
      m = ONE | {10'd0, 22'($urandom()), 32'($urandom())};
      send(1'($urandom()), 13'($urandom() % 200) - 13'd100, m, 2'($urandom()),
           1'($urandom()), 1'($urandom()), 1'b0, 1'b0, "R2 R4 R12 mixed");
      if (i % 7 == 3) idle();
    end
    idle();
    repeat (5) @(negedge clk_i);
    check("R1 output count", 64'(seen), 64'(sent));
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule